// File: doc/BRIEF.md
# Full-Map Home Directory Controller

This block is the home-node directory controller for a shared-memory multiprocessor. It keeps one entry for every memory block it owns. Each entry is a presence vector with one bit per processor, plus a dirty flag. Taken together these describe the block's condition: uncached, held by one or more readers, or held by exactly one writer.

Cache controllers send read-miss, write-miss and replacement write-back requests over a valid/ready request port. For each request the controller works out the coherence actions and emits them one at a time on a valid/ready message port:

- data supply to a reader;
- write permission to a writer;
- a recall that drops the owner to shared;
- an invalidation to a sharer;
- a memory update.

Acknowledgements for recalls and invalidations come back on a separate valid/ready port. A pending-acknowledgement counter gates the reply on them. Only one transaction is open at a time, and new requests are stalled until it completes.

Top module: `fullmap_dir`

## Requirements
- R1: After reset every entry is uncached and clean, `req_ready` is high, `msg_valid` is low and `rsp_ready` is low.
- R2: A read (`req_kind`=0) of a block whose dirty flag is clear emits a single data message (`msg_type`=0) to the requester and adds the requester to the presence vector.
- R3: A read of a block held dirty by another processor emits, in order: a recall (`msg_type`=2) to the owner; after the owner's acknowledgement, a memory update (`msg_type`=4) naming the owner; then data to the requester. The block then becomes clean, with the owner and the requester both present.
- R4: A write (`req_kind`=1) to a clean block sends an invalidation (`msg_type`=3) to every present processor other than the requester, one per message, in ascending ID order. The grant (`msg_type`=1) to the requester is issued only after that many acknowledgements have been taken.
- R5: A write to a clean block with no other sharer is granted at once, with no invalidation.
- R6: A write to a block held dirty by another processor emits, in order: an invalidation to the old owner; after its acknowledgement, a memory update naming the old owner; then the grant.
- R7: After a write completes, only the writer is present and the block is dirty. A later read by another processor therefore recalls that writer alone.
- R8: A write-back (`req_kind`=2) from the dirty owner emits one memory update naming it and leaves the block uncached. A write-back from any other processor, a write-back to a clean block, and `req_kind`=3 are accepted with no message and no change to the entry.
- R9: From the cycle after a request is accepted until its last message has been taken, `req_ready` stays low.
- R10: `rsp_ready` is high only while acknowledgements are still owed. Each accepted acknowledgement lowers the owed count by one.
- R11: A message offered while `msg_ready` is low stays valid with the same type and destination until it is taken.
- R12: A write by the processor that already holds the block dirty is granted with no invalidation and no memory update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 2 | 0 read, 1 write, 2 write-back, 3 ignored |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block index |
| msg_valid | output | 1 | Coherence message offered |
| msg_ready | input | 1 | Network takes the message |
| msg_type | output | 3 | 0 data, 1 grant, 2 recall, 3 invalidate, 4 memory update |
| msg_dst | output | $clog2(NPROC) | Target processor; for a memory update, the processor whose copy is written |
| msg_blk | output | $clog2(NBLK) | Block index of the open transaction |
| rsp_valid | input | 1 | Acknowledgement offered |
| rsp_ready | output | 1 | Acknowledgement still owed |

## Verification
The first message of a transaction appears the cycle after the request handshake, because one state register sits in between. Each following message appears the cycle after the previous one is taken. A reply that waits on acknowledgements is offered one cycle after the owed count reaches zero.

The bench never assumes a fixed latency. It logs every message handshake at the falling edge, together with the number of acknowledgements taken by then. It waits until the expected number of messages has arrived, then a short settle window, and compares the whole log against the expected sequence. A reply logged with fewer acknowledgements than probes sent counts as a failure. Acknowledgement delay and output backpressure vary from vector to vector, so the ordering checks do not depend on any one timing.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

  // Outbound coherence message codes (shared with the network side)
  typedef enum logic [2:0] {
    MSG_DATA   = 3'd0,
    MSG_GRANT  = 3'd1,
    MSG_RECALL = 3'd2,
    MSG_INVAL  = 3'd3,
    MSG_MEMWR  = 3'd4
  } fmd_msg_e;

  // Inbound request kinds
  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_WBACK = 2'd2,
    REQ_NONE  = 2'd3
  } fmd_req_e;

  // Transaction sequencer states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROBE = 3'd1,
    ST_DRAIN = 3'd2,
    ST_MEMWR = 3'd3,
    ST_REPLY = 3'd4
  } fmd_st_e;

endpackage

// File: rtl/fmd_dir_store.sv
module fmd_dir_store #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_idx,
  output logic [NPROC-1:0] rd_pres,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_idx,
  input  logic [NPROC-1:0] wr_pres,
  input  logic             wr_dirty
);

  logic [NPROC-1:0] pres_q [NBLK];
  logic [NBLK-1:0]  dirty_q;

  // One register slice per directory entry
  for (genvar b = 0; b < NBLK; b++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end else if (wr_en && (wr_idx == BW'(b))) begin
        pres_q[b]  <= wr_pres;
        dirty_q[b] <= wr_dirty;
      end
    end
  end

  assign rd_pres  = pres_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  // R7: a dirty entry always names exactly one holder
  a_r7_dirty_single_holder: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dirty) |-> ($countones(wr_pres) == 1));

  // R8: a block left uncached is also clean
  a_r8_uncached_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_pres == '0)) |-> !wr_dirty);

endmodule

// File: rtl/fmd_ack_ctr.sv
module fmd_ack_ctr #(
  parameter int NPROC = 4,
  localparam int CW   = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] load_mask,
  input  logic             take,
  output logic             pend_zero
);

  logic [CW-1:0] cnt_q;

  // Number of targets that will owe an acknowledgement
  function automatic logic [CW-1:0] owed(input logic [NPROC-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NPROC; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= owed(load_mask);
    else if (take) cnt_q <= cnt_q - CW'(1);
  end

  assign pend_zero = (cnt_q == '0);

  // R10: no acknowledgement is taken beyond the owed count
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt_q != '0));

  // R10: a new count is loaded only once the previous one has drained
  a_r10_load_drained: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));

endmodule

// File: rtl/fmd_probe_scan.sv
module fmd_probe_scan #(
  parameter int NPROC = 4,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] load_mask,
  input  logic             advance,
  output logic [PW-1:0]    cur_id,
  output logic             last
);

  logic [NPROC-1:0] mask_q;

  // Lowest set position gives ascending-ID probe order
  function automatic logic [PW-1:0] lowest(input logic [NPROC-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPROC - 1; i >= 0; i--) if (v[i]) r = PW'(i);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (load)    mask_q <= load_mask;
    else if (advance) mask_q <= mask_q & ~(NPROC'(1) << cur_id);
  end

  assign cur_id = lowest(mask_q);
  assign last   = ((mask_q & (mask_q - NPROC'(1))) == '0);

  // R4: each sent probe retires exactly one target
  a_r4_one_target_per_probe: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ($countones(mask_q) + 1 == $past($countones(mask_q))));

  // R4: a probe is only sent while a target remains
  a_r4_probe_has_target: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (mask_q != '0));

endmodule

// File: rtl/fullmap_dir.sv
module fullmap_dir
  import fmd_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [PW-1:0] req_src,
  input  logic [BW-1:0] req_blk,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [2:0]    msg_type,
  output logic [PW-1:0] msg_dst,
  output logic [BW-1:0] msg_blk,
  input  logic          rsp_valid,
  output logic          rsp_ready
);

  // Entry read/write
  logic [NPROC-1:0] rd_pres;
  logic             rd_dirty;
  logic             wr_en;

  // Transaction registers
  fmd_st_e          st_q;
  logic [PW-1:0]    src_q;
  logic [BW-1:0]    blk_q;
  fmd_msg_e         probe_q;
  fmd_msg_e         reply_q;
  logic             mem_q;
  logic             wb_q;
  logic [PW-1:0]    memdst_q;
  logic [NPROC-1:0] npres_q;
  logic             ndirty_q;

  // Named events for the checks
  logic             accept;
  logic             msg_hs;
  logic             ack_take;
  logic             ack_zero;
  logic             finish;
  logic [PW-1:0]    scan_id;
  logic             scan_last;

  // Decode of the incoming request against the current entry
  logic [NPROC-1:0] own_bit;
  logic [NPROC-1:0] others;
  logic             owner_other;
  logic             wb_ok;
  logic             d_go;
  logic [NPROC-1:0] d_mask;
  fmd_msg_e         d_probe;
  fmd_msg_e         d_reply;
  logic             d_mem;
  logic             d_wb;
  logic [NPROC-1:0] d_pres;
  logic             d_dirty;

  fmd_dir_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_blk),
    .rd_pres  (rd_pres),
    .rd_dirty (rd_dirty),
    .wr_en    (wr_en),
    .wr_idx   (blk_q),
    .wr_pres  (npres_q),
    .wr_dirty (ndirty_q)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign msg_hs    = msg_valid && msg_ready;
  assign rsp_ready = !ack_zero;
  assign ack_take  = rsp_valid && rsp_ready;

  assign own_bit     = NPROC'(1) << req_src;
  assign others      = rd_pres & ~own_bit;
  assign owner_other = rd_dirty && (others != '0);
  assign wb_ok       = rd_dirty && rd_pres[req_src];

  always_comb begin
    d_go    = 1'b0;
    d_mask  = '0;
    d_probe = MSG_INVAL;
    d_reply = MSG_DATA;
    d_mem   = 1'b0;
    d_wb    = 1'b0;
    d_pres  = rd_pres;
    d_dirty = rd_dirty;
    unique case (fmd_req_e'(req_kind))
      REQ_READ: begin
        d_go    = 1'b1;
        d_pres  = rd_pres | own_bit;
        if (owner_other) begin
          d_mask  = others;
          d_probe = MSG_RECALL;
          d_mem   = 1'b1;
          d_dirty = 1'b0;
        end
      end
      REQ_WRITE: begin
        d_go    = 1'b1;
        d_reply = MSG_GRANT;
        d_mask  = others;
        d_mem   = owner_other;
        d_pres  = own_bit;
        d_dirty = 1'b1;
      end
      REQ_WBACK: begin
        if (wb_ok) begin
          d_go    = 1'b1;
          d_wb    = 1'b1;
          d_mem   = 1'b1;
          d_pres  = '0;
          d_dirty = 1'b0;
        end
      end
      default: ;
    endcase
  end

  fmd_probe_scan #(.NPROC(NPROC)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && d_go),
    .load_mask (d_mask),
    .advance   (msg_hs && (st_q == ST_PROBE)),
    .cur_id    (scan_id),
    .last      (scan_last)
  );

  fmd_ack_ctr #(.NPROC(NPROC)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && d_go),
    .load_mask (d_mask),
    .take      (ack_take),
    .pend_zero (ack_zero)
  );

  assign finish = msg_hs && ((st_q == ST_REPLY) || ((st_q == ST_MEMWR) && wb_q));
  assign wr_en  = finish;

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      src_q    <= '0;
      blk_q    <= '0;
      probe_q  <= MSG_INVAL;
      reply_q  <= MSG_DATA;
      mem_q    <= 1'b0;
      wb_q     <= 1'b0;
      memdst_q <= '0;
      npres_q  <= '0;
      ndirty_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept && d_go) begin
            src_q    <= req_src;
            blk_q    <= req_blk;
            probe_q  <= d_probe;
            reply_q  <= d_reply;
            mem_q    <= d_mem;
            wb_q     <= d_wb;
            memdst_q <= req_src;
            npres_q  <= d_pres;
            ndirty_q <= d_dirty;
            if (d_mask != '0) st_q <= ST_PROBE;
            else if (d_wb)    st_q <= ST_MEMWR;
            else              st_q <= ST_REPLY;
          end
        end
        ST_PROBE: begin
          if (msg_hs) begin
            memdst_q <= scan_id;
            if (scan_last) st_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (ack_zero) st_q <= mem_q ? ST_MEMWR : ST_REPLY;
        end
        ST_MEMWR: begin
          if (msg_hs) st_q <= wb_q ? ST_IDLE : ST_REPLY;
        end
        ST_REPLY: begin
          if (msg_hs) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Message port
  always_comb begin
    msg_valid = 1'b0;
    msg_type  = MSG_DATA;
    msg_dst   = src_q;
    unique case (st_q)
      ST_PROBE: begin
        msg_valid = 1'b1;
        msg_type  = probe_q;
        msg_dst   = scan_id;
      end
      ST_MEMWR: begin
        msg_valid = 1'b1;
        msg_type  = MSG_MEMWR;
        msg_dst   = memdst_q;
      end
      ST_REPLY: begin
        msg_valid = 1'b1;
        msg_type  = reply_q;
        msg_dst   = src_q;
      end
      default: ;
    endcase
  end

  assign msg_blk = blk_q;

  // R4, R3, R6: replies and memory updates only after all acks are in
  a_r4_reply_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_type == MSG_GRANT || msg_type == MSG_DATA || msg_type == MSG_MEMWR))
      |-> ack_zero);

  // R3: a recall goes to a single owner
  a_r3_single_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == MSG_RECALL) |-> scan_last);

  // R9: an accepted transaction stalls the request port
  a_r9_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && d_go) |=> !req_ready);

  // R11: an offered message is held steady under backpressure
  a_r11_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type) && $stable(msg_dst)));

endmodule

// File: tb/fullmap_dir_tb_top.sv
module fullmap_dir_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPROC = 4;
  localparam int NBLK  = 16;
  localparam int NV    = 22;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2, K_NO = 2'd3;
  localparam logic [2:0] T_D = 3'd0, T_G = 3'd1, T_R = 3'd2, T_I = 3'd3, T_M = 3'd4;

  // {kind, src, blk, tag, count, 5 x {type, dst}}
  localparam logic [39:0] VEC [NV] = '{
    {K_RD, 2'd1, 4'd0,  4'd2,  3'd1, {T_D,2'd1}, 20'd0},                                // R2
    {K_RD, 2'd2, 4'd0,  4'd2,  3'd1, {T_D,2'd2}, 20'd0},                                // R2
    {K_WR, 2'd3, 4'd0,  4'd4,  3'd3, {T_I,2'd1}, {T_I,2'd2}, {T_G,2'd3}, 10'd0},        // R4
    {K_RD, 2'd0, 4'd0,  4'd3,  3'd3, {T_R,2'd3}, {T_M,2'd3}, {T_D,2'd0}, 10'd0},        // R3
    {K_WR, 2'd0, 4'd0,  4'd4,  3'd2, {T_I,2'd3}, {T_G,2'd0}, 15'd0},                    // R4
    {K_WR, 2'd0, 4'd0,  4'd12, 3'd1, {T_G,2'd0}, 20'd0},                                // R12
    {K_WR, 2'd1, 4'd0,  4'd6,  3'd3, {T_I,2'd0}, {T_M,2'd0}, {T_G,2'd1}, 10'd0},        // R6
    {K_WB, 2'd2, 4'd0,  4'd8,  3'd0, 25'd0},                                            // R8
    {K_RD, 2'd2, 4'd0,  4'd7,  3'd3, {T_R,2'd1}, {T_M,2'd1}, {T_D,2'd2}, 10'd0},        // R7
    {K_WR, 2'd3, 4'd1,  4'd5,  3'd1, {T_G,2'd3}, 20'd0},                                // R5
    {K_WB, 2'd3, 4'd1,  4'd8,  3'd1, {T_M,2'd3}, 20'd0},                                // R8
    {K_WR, 2'd0, 4'd1,  4'd8,  3'd1, {T_G,2'd0}, 20'd0},                                // R8
    {K_WB, 2'd0, 4'd0,  4'd8,  3'd0, 25'd0},                                            // R8
    {K_WR, 2'd3, 4'd0,  4'd4,  3'd3, {T_I,2'd1}, {T_I,2'd2}, {T_G,2'd3}, 10'd0},        // R4
    {K_RD, 2'd2, 4'd5,  4'd2,  3'd1, {T_D,2'd2}, 20'd0},                                // R2
    {K_WR, 2'd1, 4'd5,  4'd4,  3'd2, {T_I,2'd2}, {T_G,2'd1}, 15'd0},                    // R4
    {K_RD, 2'd0, 4'd15, 4'd2,  3'd1, {T_D,2'd0}, 20'd0},                                // R2
    {K_RD, 2'd1, 4'd15, 4'd2,  3'd1, {T_D,2'd1}, 20'd0},                                // R2
    {K_RD, 2'd2, 4'd15, 4'd2,  3'd1, {T_D,2'd2}, 20'd0},                                // R2
    {K_WR, 2'd3, 4'd15, 4'd4,  3'd4, {T_I,2'd0}, {T_I,2'd1}, {T_I,2'd2}, {T_G,2'd3}, 5'd0}, // R4
    {K_NO, 2'd1, 4'd15, 4'd8,  3'd0, 25'd0},                                            // R8
    {K_RD, 2'd0, 4'd15, 4'd7,  3'd3, {T_R,2'd3}, {T_M,2'd3}, {T_D,2'd0}, 10'd0}         // R7
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_kind;
  logic [1:0] req_src;
  logic [3:0] req_blk;
  logic       msg_valid;
  logic       msg_ready;
  logic [2:0] msg_type;
  logic [1:0] msg_dst;
  logic [3:0] msg_blk;
  logic       rsp_valid;
  logic       rsp_ready;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int log_n    = 0;
  int acks     = 0;
  int qh       = 0;
  int qt       = 0;
  int ack_dly  = 1;
  int hold_seen = 0;
  bit bp_en    = 1'b0;
  bit hold_pend = 1'b0;
  logic [2:0] hold_t;
  logic [1:0] hold_d;
  logic [2:0] log_t [16];
  logic [1:0] log_d [16];
  int         log_a [16];
  int         ackq  [64];

  fullmap_dir #(.NPROC(NPROC), .NBLK(NBLK)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_src   (req_src),
    .req_blk   (req_blk),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_type  (msg_type),
    .msg_dst   (msg_dst),
    .msg_blk   (msg_blk),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Network model: logs messages, returns acks after a delay, applies backpressure
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected under 150000", cyc);
      finish_run();
    end
    if (hold_pend) begin  // R11
      n_checks++; hold_seen++;
      if (!(msg_valid && msg_type == hold_t && msg_dst == hold_d)) begin
        n_fail++;
        $display("FAIL R11 held message changed: actual v%0d t%0d d%0d expected v1 t%0d d%0d",
                 msg_valid, msg_type, msg_dst, hold_t, hold_d);
      end
    end
    msg_ready = bp_en ? ((cyc % 3) != 1) : 1'b1;
    if (msg_valid && msg_ready && log_n < 16) begin
      log_t[log_n] = msg_type;
      log_d[log_n] = msg_dst;
      log_a[log_n] = acks;
      log_n++;
      if (msg_type == T_R || msg_type == T_I) begin
        ackq[qt % 64] = cyc + ack_dly;
        qt++;
      end
    end
    hold_pend = msg_valid && !msg_ready;
    hold_t = msg_type;
    hold_d = msg_dst;
    rsp_valid = (qh != qt) && (cyc >= ackq[qh % 64]);
    if (rsp_valid && rsp_ready) begin
      qh++;
      acks++;
    end
  end

  task automatic check(input bit ok, input int tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] k, input logic [1:0] s, input logic [3:0] b,
                         input int tag, input int n, input logic [24:0] ex,
                         input bit bp, input int dly);
    bit stall_bad;
    int w;
    int probes;
    logic [4:0] e;
    bp_en = bp;
    ack_dly = dly;
    @(negedge clk);
    log_n = 0; acks = 0;
    req_valid = 1'b1; req_kind = k; req_src = s; req_blk = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    stall_bad = 1'b0;
    w = 0;
    while (log_n < n && w < 80) begin
      if (req_ready) stall_bad = 1'b1;
      @(negedge clk);
      w++;
    end
    repeat (6) @(negedge clk);
    check(log_n == n, tag, "message count", log_n, n);
    if (n > 0) check(!stall_bad, 9, "request port open mid-transaction (R9)", stall_bad, 0);
    probes = 0;
    for (int i = 0; i < n; i++) begin
      e = ex[24 - 5*i -: 5];
      if (e[4:2] == T_R || e[4:2] == T_I) probes++;
    end
    for (int i = 0; i < n && i < log_n; i++) begin
      e = ex[24 - 5*i -: 5];
      check(log_t[i] == e[4:2], tag, "message type", log_t[i], e[4:2]);
      check(log_d[i] == e[1:0], tag, "message destination", log_d[i], e[1:0]);
      if (e[4:2] == T_D || e[4:2] == T_G || e[4:2] == T_M)
        check(log_a[i] == probes, 10, "acks taken before reply (R4/R10)", log_a[i], probes);
    end
    check(req_ready == 1'b1, 9, "request port reopened (R9)", req_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_src = '0; req_blk = '0;
    msg_ready = 1'b1; rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(req_ready == 1'b1, 1, "req_ready after reset", req_ready, 1);
    check(msg_valid == 1'b0, 1, "msg_valid after reset", msg_valid, 0);
    check(rsp_ready == 1'b0, 1, "rsp_ready after reset", rsp_ready, 0);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      run_one(v[39:38], v[37:36], v[35:32], int'(v[31:28]), int'(v[27:25]), v[24:0],
              i[0], 1 + (i % 3) * 3);
    end

    // R10: nothing owed while idle
    check(rsp_ready == 1'b0, 10, "rsp_ready while idle", rsp_ready, 0);
    // R11: backpressure was actually exercised
    check(hold_seen > 0, 11, "held messages observed", hold_seen, 1);

    // R1: a mid-run reset empties the directory (block 0 was dirty at node 3)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, 1, "req_ready after second reset", req_ready, 1);
    run_one(K_WR, 2'd1, 4'd0, 1, 1, {T_G, 2'd1, 20'd0}, 1'b0, 1);
    // R12 with backpressure: owner rewrites
    run_one(K_WR, 2'd1, 4'd0, 12, 1, {T_G, 2'd1, 20'd0}, 1'b1, 1);
    // R5: fresh block, lone writer
    run_one(K_WR, 2'd2, 4'd9, 5, 1, {T_G, 2'd2, 20'd0}, 1'b0, 1);

    finish_run();
  end

endmodule